// File: doc/BRIEF.md
# SPI Command-Queue FIFO Controller

This block is the front end of a master-side serial controller. A bus master, usually a DMA engine, writes command-plus-data entries into a four-deep transmit FIFO. It takes received words out of a four-deep receive FIFO through a pop register. A frame engine takes one entry at a time. In this model it loops the data straight back: after a fixed number of cycles the frame completes and its data word enters the receive FIFO. Baud-rate generation, chip-select timing and multi-lane modes sit outside this block.

Each transmit entry carries two command bits. One clears a 16-bit transfer counter when the frame starts. The other raises an end-of-queue status flag when the frame completes. While that flag is set, no new frame starts. Software can therefore retarget its DMA queues, flush either FIFO and reload the counter before it clears the flag to resume. Two request outputs tell the bus master when the transmit FIFO has room and when the receive FIFO holds data.

All access goes through a word-addressed register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. A read of the pop register removes the entry it shows at that same edge.

Top module: `spi_cmdq_ctrl`

## Requirements
- R1: After reset both FIFOs are empty, the counter is 0, all status flags are 0, `tx_fill_req` is 1 and `rx_drain_req` is 0.
- R2: A write to address 3 pushes an entry with data in bits [15:0], end-of-queue in bit 16 and clear-counter in bit 17. Entries are framed in push order. Each frame lasts 4 cycles, with at least one idle cycle before the next frame starts. The frame's data then enters the receive FIFO.
- R3: A read of address 4 returns the receive head in bits [15:0] and removes it. A read of address 4 on an empty FIFO returns 0 and changes nothing.
- R4: The status register (address 1) holds the receive count in [3:0], the transmit count in [7:4] and a receive-available bit in 8.
- R5: Writing 1 to bit 0 of the control register (address 0) empties the transmit FIFO. A frame already in progress still completes. The control register always reads 0.
- R6: Writing 1 to bit 1 of the control register empties the receive FIFO.
- R7: The transfer counter (address 2, bits [15:0]) increments once per completed frame and wraps from 0xFFFF to 0.
- R8: An entry with the clear-counter bit zeroes the counter when its frame starts. Its completion then counts it, so the counter reads 1.
- R9: A write to address 2 loads the counter directly.
- R10: An entry with the end-of-queue bit sets status bit 9 when its frame completes. While bit 9 is set, no frame starts. Writing 1 to bit 9 clears it and framing resumes.
- R11: `tx_fill_req` is 1 exactly when the transmit FIFO is not full. `rx_drain_req` is 1 exactly when the receive FIFO is not empty.
- R12: A push to a full transmit FIFO is dropped and sets status bit 10. A completed frame that meets a full receive FIFO is dropped and sets bit 11. Writing 1 to either bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 4) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| tx_fill_req | output | 1 | Transmit FIFO has room |
| rx_drain_req | output | 1 | Receive FIFO holds data |

## Verification
The assertions check, on every cycle, the invariants that hold over single steps. These are the counter stepping by one per completed frame, zeroing on a clear-counter start, a set end-of-queue flag holding the engine idle, flushes emptying their FIFO on the next edge, pops shrinking the receive count, and the request outputs tracking FIFO occupancy. Only the bench scenarios can show data order across a whole queue, the drop of a fifth push into a stalled queue, a receive overflow after resuming, completion of an in-flight frame across a flush, and the counter wrapping. The bench compares against a queue-based reference model on every cycle.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 32;

    typedef struct packed {
        logic              clr_cnt;
        logic              eoq;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    localparam int ENTRY_W = $bits(tx_entry_t);

    typedef enum logic [2:0] {
        ADDR_CTRL   = 3'd0,
        ADDR_STAT   = 3'd1,
        ADDR_XCNT   = 3'd2,
        ADDR_TXPUSH = 3'd3,
        ADDR_RXPOP  = 3'd4
    } reg_addr_e;

    localparam int CTRL_TXFLUSH = 0;
    localparam int CTRL_RXFLUSH = 1;
    localparam int ST_RXAVAIL   = 8;
    localparam int ST_EOQ       = 9;
    localparam int ST_TXOVF     = 10;
    localparam int ST_RXOVF     = 11;

    function automatic logic [REG_W-1:0] pack_status(
        input logic [3:0] rx_cnt,
        input logic [3:0] tx_cnt,
        input logic       avail,
        input logic       eoq,
        input logic       tx_ovf,
        input logic       rx_ovf
    );
        logic [REG_W-1:0] s;
        s              = '0;
        s[3:0]         = rx_cnt;
        s[7:4]         = tx_cnt;
        s[ST_RXAVAIL]  = avail;
        s[ST_EOQ]      = eoq;
        s[ST_TXOVF]    = tx_ovf;
        s[ST_RXOVF]    = rx_ovf;
        return s;
    endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/cmdq_shifter.sv
module cmdq_shifter
    import spi_cmdq_pkg::*;
#(
    parameter int FRAME_CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      can_start,
    input  tx_entry_t entry_in,
    output logic      start,
    output logic      done,
    output logic      busy,
    output tx_entry_t cur
);
    localparam int LW = $clog2(FRAME_CYC+1);

    logic [LW-1:0] left;

    assign start = can_start && !busy;
    assign done  = busy && (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
            cur  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= LW'(FRAME_CYC-1);
            cur  <= entry_in;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            left <= left - 1'b1;
        end
    end

endmodule

// File: rtl/spi_cmdq_ctrl.sv
module spi_cmdq_ctrl
    import spi_cmdq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int FRAME_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_fill_req,
    output logic        rx_drain_req
);
    localparam int CW = $clog2(DEPTH+1);

    reg_addr_e             addr;
    logic                  ctrl_wr, stat_wr, cnt_wr;
    logic                  tx_flush, rx_flush, tx_push, rx_pop;
    tx_entry_t             tx_in, tx_head, cur;
    logic [CW-1:0]         tx_count, rx_count;
    logic                  tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0]     rx_head;
    logic                  start, done, busy;
    logic [CNT_W-1:0]      xfer_cnt;
    logic                  eoq_q, tx_ovf_q, rx_ovf_q;

    assign addr     = reg_addr_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (addr == ADDR_CTRL);
    assign stat_wr  = reg_wr && (addr == ADDR_STAT);
    assign cnt_wr   = reg_wr && (addr == ADDR_XCNT);
    assign tx_push  = reg_wr && (addr == ADDR_TXPUSH);
    assign rx_pop   = reg_rd && (addr == ADDR_RXPOP);
    assign tx_flush = ctrl_wr && reg_wdata[CTRL_TXFLUSH];
    assign rx_flush = ctrl_wr && reg_wdata[CTRL_RXFLUSH];
    assign tx_in    = tx_entry_t'(reg_wdata[ENTRY_W-1:0]);

    cmdq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_flush),
        .push  (tx_push),
        .pop   (start),
        .wdata (tx_in),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    cmdq_shifter #(.FRAME_CYC(FRAME_CYC)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .can_start (!tx_empty && !eoq_q),
        .entry_in  (tx_head),
        .start     (start),
        .done      (done),
        .busy      (busy),
        .cur       (cur)
    );

    cmdq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_flush),
        .push  (done),
        .pop   (rx_pop),
        .wdata (cur.data),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_cnt <= '0;
        end else if (cnt_wr) begin
            xfer_cnt <= reg_wdata[CNT_W-1:0];
        end else if (start && tx_head.clr_cnt) begin
            xfer_cnt <= '0;
        end else if (done) begin
            xfer_cnt <= xfer_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eoq_q    <= 1'b0;
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            if (done && cur.eoq)                   eoq_q <= 1'b1;
            else if (stat_wr && reg_wdata[ST_EOQ]) eoq_q <= 1'b0;

            if (tx_push && tx_full && !tx_flush)     tx_ovf_q <= 1'b1;
            else if (stat_wr && reg_wdata[ST_TXOVF]) tx_ovf_q <= 1'b0;

            if (done && rx_full && !rx_flush)        rx_ovf_q <= 1'b1;
            else if (stat_wr && reg_wdata[ST_RXOVF]) rx_ovf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_STAT:  reg_rdata = pack_status(4'(rx_count), 4'(tx_count), !rx_empty,
                                                eoq_q, tx_ovf_q, rx_ovf_q);
            ADDR_XCNT:  reg_rdata = {{(REG_W-CNT_W){1'b0}}, xfer_cnt};
            ADDR_RXPOP: reg_rdata = rx_empty ? '0 : {{(REG_W-DATA_W){1'b0}}, rx_head};
            default:    reg_rdata = '0;
        endcase
    end

    assign tx_fill_req  = !tx_full;
    assign rx_drain_req = !rx_empty;

endmodule

// File: rtl/spi_cmdq_chk.sv
module spi_cmdq_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             rx_pop,
    input logic             cnt_wr,
    input logic             start,
    input logic             start_clr,
    input logic             done,
    input logic             done_eoq,
    input logic             busy,
    input logic             eoq_flag,
    input logic [CNT_W-1:0] xfer_cnt,
    input logic [CW-1:0]    tx_count,
    input logic [CW-1:0]    rx_count,
    input logic             tx_fill_req,
    input logic             rx_drain_req
);
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (done && !cnt_wr) |=> xfer_cnt == CNT_W'($past(xfer_cnt) + 1'b1));

    a_r8_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        (start && start_clr && !cnt_wr) |=> xfer_cnt == '0);

    a_r10_eoq_sets: assert property (@(posedge clk) disable iff (rst)
        (done && done_eoq) |=> eoq_flag);

    a_r10_eoq_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (eoq_flag && !busy) |=> !busy);

    a_r5_tx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> tx_count == '0);

    a_r6_rx_flush_empties: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> rx_count == '0);

    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_count != '0 && !done && !rx_flush) |=> rx_count == CW'($past(rx_count) - 1'b1));

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH));

    a_r11_requests: assert property (@(posedge clk) disable iff (rst)
        tx_fill_req == (tx_count != CW'(DEPTH)) && rx_drain_req == (rx_count != '0));

endmodule

bind spi_cmdq_ctrl spi_cmdq_chk #(
    .DEPTH (DEPTH),
    .CW    ($clog2(DEPTH+1)),
    .CNT_W (spi_cmdq_pkg::CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .rx_pop       (rx_pop),
    .cnt_wr       (cnt_wr),
    .start        (start),
    .start_clr    (tx_head.clr_cnt),
    .done         (done),
    .done_eoq     (cur.eoq),
    .busy         (busy),
    .eoq_flag     (eoq_q),
    .xfer_cnt     (xfer_cnt),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_fill_req  (tx_fill_req),
    .rx_drain_req (rx_drain_req)
);

// File: tb/test_spi_cmdq_ctrl.sv
`timescale 1ns/1ps
module test_spi_cmdq_ctrl;
    localparam int DEPTH = 4;
    localparam int FRAME = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        tx_fill_req, rx_drain_req;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_cmdq_ctrl #(.DEPTH(DEPTH), .FRAME_CYC(FRAME)) i_spi_cmdq_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_fill_req(tx_fill_req), .rx_drain_req(rx_drain_req)
    );

    // reference model state
    logic [17:0] txq[$];
    logic [15:0] rxq[$];
    bit          m_busy;
    int          m_left;
    logic [17:0] m_cur;
    logic [15:0] m_cnt;
    bit          m_eoq, m_txovf, m_rxovf;

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            m_busy = 0; m_left = 0; m_cur = '0; m_cnt = '0;
            m_eoq = 0; m_txovf = 0; m_rxovf = 0;
        end else begin
            bit start, done, txf, rxf, w1c_st;
            logic [17:0] head, prev_cur;
            int ts, rs;
            ts = txq.size(); rs = rxq.size();
            start = !m_busy && !m_eoq && ts > 0;
            done  = m_busy && m_left == 0;
            head  = (ts > 0) ? txq[0] : '0;
            prev_cur = m_cur;
            txf = reg_wr && reg_addr == 3'd0 && reg_wdata[0];
            rxf = reg_wr && reg_addr == 3'd0 && reg_wdata[1];
            w1c_st = reg_wr && reg_addr == 3'd1;
            // transmit queue
            if (txf) txq.delete();
            else begin
                if (reg_wr && reg_addr == 3'd3 && ts == DEPTH) m_txovf = 1;
                else if (w1c_st && reg_wdata[10]) m_txovf = 0;
                if (start) void'(txq.pop_front());
                if (reg_wr && reg_addr == 3'd3 && ts < DEPTH) txq.push_back(reg_wdata[17:0]);
            end
            if (txf && w1c_st && reg_wdata[10]) m_txovf = 0;
            // receive queue
            if (rxf) rxq.delete();
            else begin
                if (done && rs == DEPTH) m_rxovf = 1;
                else if (w1c_st && reg_wdata[11]) m_rxovf = 0;
                if (reg_rd && reg_addr == 3'd4 && rs > 0) void'(rxq.pop_front());
                if (done && rs < DEPTH) rxq.push_back(prev_cur[15:0]);
            end
            // counter
            if (reg_wr && reg_addr == 3'd2) m_cnt = reg_wdata[15:0];
            else if (start && head[17]) m_cnt = '0;
            else if (done) m_cnt = m_cnt + 16'd1;
            // end-of-queue flag
            if (done && prev_cur[16]) m_eoq = 1;
            else if (w1c_st && reg_wdata[9]) m_eoq = 0;
            // engine
            if (start) begin m_busy = 1; m_left = FRAME - 1; m_cur = head; end
            else if (done) m_busy = 0;
            else if (m_busy) m_left = m_left - 1;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd1: begin
                v[3:0] = 4'(rxq.size()); v[7:4] = 4'(txq.size());
                v[8] = rxq.size() > 0; v[9] = m_eoq; v[10] = m_txovf; v[11] = m_rxovf;
            end
            3'd2: v[15:0] = m_cnt;
            3'd4: if (rxq.size() > 0) v[15:0] = rxq[0];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R11: request outputs compared with the model on every cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R11 tx_fill_req", {31'd0, tx_fill_req}, {31'd0, txq.size() < DEPTH});
            check("R11 rx_drain_req", {31'd0, rx_drain_req}, {31'd0, rxq.size() > 0});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            reg_wr = 0; reg_rd = 0; reg_addr = 3'd1;
        end
    endtask

    task automatic rd_model(input string tag, input logic [2:0] a);
        @(negedge clk);
        reg_wr = 0; reg_rd = 1; reg_addr = a;
        #1 check(tag, reg_rdata, m_read(a));
    endtask

    task automatic rd_exp(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_wr = 0; reg_rd = 1; reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd_exp("R1 status", 3'd1, 32'h0);
        rd_exp("R1 counter", 3'd2, 32'h0);
        check("R1 tx_fill_req", {31'd0, tx_fill_req}, 32'd1);

        // R2 framing order, R4 status, R7 counting, R3 pop
        wr(3'd3, 32'h0000_00A1);
        wr(3'd3, 32'h0000_00B2);
        wr(3'd3, 32'h0000_00C3);
        idle(20);
        rd_exp("R4 status three", 3'd1, 32'h0000_0103);
        rd_exp("R7 counter three", 3'd2, 32'd3);
        rd_exp("R2 first", 3'd4, 32'h00A1);
        rd_exp("R2 second", 3'd4, 32'h00B2);
        rd_exp("R2 third", 3'd4, 32'h00C3);
        rd_exp("R3 empty pop", 3'd4, 32'h0);
        rd_exp("R3 empty status", 3'd1, 32'h0);

        // R10 end-of-queue stall, R12 transmit overflow
        wr(3'd3, 32'h0001_0011);
        idle(8);
        rd_model("R10 eoq set", 3'd1);
        for (int i = 0; i < 5; i++) wr(3'd3, 32'h0000_0020 + i);
        idle(12);
        rd_exp("R12 tx overflow", 3'd1, 32'h0000_0741);
        rd_exp("R10 no frames while stalled", 3'd2, 32'd4);

        // R5 transmit flush, control reads 0
        wr(3'd0, 32'h1);
        idle(1);
        rd_model("R5 tx flushed", 3'd1);
        rd_exp("R5 ctrl reads zero", 3'd0, 32'h0);

        // R10 / R12 clear by writing 1
        wr(3'd1, 32'h0000_0600);
        idle(1);
        rd_exp("R10 eoq cleared", 3'd1, 32'h0000_0101);

        // R12 receive overflow after resume
        for (int i = 0; i < 4; i++) wr(3'd3, 32'h0000_0040 + i);
        idle(30);
        rd_exp("R12 rx overflow", 3'd1, 32'h0000_0904);
        rd_model("R2 oldest kept", 3'd4);

        // R6 receive flush
        wr(3'd0, 32'h2);
        idle(1);
        rd_exp("R6 rx flushed", 3'd1, 32'h0000_0800);
        check("R6 drain req", {31'd0, rx_drain_req}, 32'd0);
        wr(3'd1, 32'h0000_0800);

        // R5 in-flight frame completes across flush
        wr(3'd3, 32'h0000_0077);
        wr(3'd3, 32'h0000_0078);
        idle(2);
        wr(3'd0, 32'h1);
        idle(10);
        rd_model("R5 in-flight status", 3'd1);
        rd_exp("R5 in-flight data", 3'd4, 32'h0077);

        // R9 direct load, R7 wrap
        wr(3'd2, 32'h0000_FFFE);
        idle(1);
        rd_exp("R9 load", 3'd2, 32'h0000_FFFE);
        wr(3'd3, 32'h0000_0001);
        wr(3'd3, 32'h0000_0002);
        idle(15);
        rd_exp("R7 wrap", 3'd2, 32'h0);
        wr(3'd0, 32'h2);

        // R8 clear-counter command bit
        wr(3'd2, 32'h0000_1234);
        wr(3'd3, 32'h0002_0055);
        idle(10);
        rd_exp("R8 clear then count", 3'd2, 32'd1);
        rd_model("R8 status", 3'd1);
        idle(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule